// File: doc/BRIEF.md
# Synthesizer Serial Word Loader

This block receives the programming words of a frequency synthesizer over three wires: a serial clock, a serial data line and a load-enable line. All three are sampled by the system clock `clk`. Every rising edge seen on the serial clock moves one data bit into a 19-bit shift register. The last bit shifted in is a steering bit. It decides where the word goes when load-enable is high. If the steering bit is 1, the word goes to the reference latch: a 14-bit reference count plus a prescaler-modulus select bit. If the steering bit is 0, the word goes to the divider latch: an 11-bit main count plus a 7-bit swallow count.

Both latches drive their fields as parallel outputs to the divider logic. They hold their values between transfers. The block also drives a switch-enable output that tracks load-enable. The loop filter uses this output as a speed-up switch while a new word is being applied. Load-enable is pulled up outside the block, so an open pin behaves as a held-high load. In that case the selected latch follows the shift register on every cycle.

Top module: `synth_serial_loader`

## Requirements
- R1: A synchronous reset (`rst` high at a rising `clk` edge) clears all latch outputs and `sw_en` to zero on that edge.
- R2: A 0-to-1 change of `ser_clk` between two consecutive `clk` samples shifts `ser_data` into the LSB end of the shift register, so words are sent MSB first. A `ser_clk` that stays high or stays low shifts nothing.
- R3: When `load_en` is sampled high and the last bit shifted in is 1, the previous 15 bits are transferred to the reference latch. The first 14 of those bits, MSB first, become `ref_count`. The 15th becomes `mod_sel`. The divider outputs are unchanged.
- R4: When `load_en` is sampled high and the last bit shifted in is 0, the previous 18 bits are transferred to the divider latch. The first 11, MSB first, become `main_count`. The next 7 become `swallow_count`. The reference outputs are unchanged.
- R5: While `load_en` is low, every latch output keeps its value, whatever is shifted in.
- R6: `sw_en` equals the value of `load_en` sampled at the previous `clk` edge.
- R7: `mod_sel` = 0 requests the 64/65 prescaler modulus and `mod_sel` = 1 requests 128/129. The bit is carried without change from its position in the reference word.
- R8: When a shift and a transfer occur at the same `clk` edge, the transfer uses the shift-register contents from before that shift.
- R9: With `load_en` held high (open pin) during a whole frame, the selected latch holds that frame once its last bit has been shifted in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_clk | input | 1 | Serial shift clock, sampled by `clk` |
| ser_data | input | 1 | Serial data bit |
| load_en | input | 1 | Latch transfer enable (pulled high externally) |
| ref_count | output | 14 | Latched reference count |
| mod_sel | output | 1 | Prescaler modulus select (0: 64/65, 1: 128/129) |
| swallow_count | output | 7 | Latched swallow count |
| main_count | output | 11 | Latched main count |
| sw_en | output | 1 | Speed-up switch enable, follows `load_en` |

## Verification
A serial clock edge and a high load-enable can fall in the same `clk` cycle. When they do, the shift and the latch transfer compete for the same register contents. The bench provokes this by raising `ser_clk` and `load_en` on the same half-cycle, right after a complete reference frame, with a different data bit on the line. The latched value is then compared against the frame computed before the extra bit. The only passing result is that the frame is latched unchanged and the extra bit does not reach it.

// File: rtl/ssl_pkg.sv
package ssl_pkg;
    localparam int REF_CNT_W_DEF = 14;
    localparam int SWAL_W_DEF    = 7;
    localparam int MAIN_W_DEF    = 11;

    typedef enum logic {
        DEST_DIV = 1'b0,
        DEST_REF = 1'b1
    } dest_e;
endpackage

// File: rtl/ssl_shifter.sv
module ssl_shifter #(
    parameter int SH_W = 19
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ser_clk,
    input  logic            ser_data,
    output logic [SH_W-1:0] word,
    output logic            rise
);
    typedef struct packed {
        logic [SH_W-1:0] sh;
        logic            clk_prev;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.clk_prev = ser_clk;
        if (ser_clk && !st_q.clk_prev) begin
            st_d.sh = {st_q.sh[SH_W-2:0], ser_data};
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign word = st_q.sh;
    assign rise = ser_clk & ~st_q.clk_prev;
endmodule

// File: rtl/ssl_hold_reg.sv
module ssl_hold_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    logic [W-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (load) begin
            val_d = din;
        end
        if (rst) begin
            val_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        val_q <= val_d;
    end

    assign q = val_q;
endmodule

// File: rtl/synth_serial_loader.sv
module synth_serial_loader
    import ssl_pkg::*;
#(
    parameter int REF_CNT_W = REF_CNT_W_DEF,
    parameter int SWAL_W    = SWAL_W_DEF,
    parameter int MAIN_W    = MAIN_W_DEF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ser_clk,
    input  logic                 ser_data,
    input  logic                 load_en,
    output logic [REF_CNT_W-1:0] ref_count,
    output logic                 mod_sel,
    output logic [SWAL_W-1:0]    swallow_count,
    output logic [MAIN_W-1:0]    main_count,
    output logic                 sw_en
);
    localparam int REF_W = REF_CNT_W + 1;
    localparam int DIV_W = SWAL_W + MAIN_W;
    localparam int SH_W  = ((DIV_W > REF_W) ? DIV_W : REF_W) + 1;

    typedef struct packed {
        logic sw;
    } top_state_t;

    top_state_t   ts_d, ts_q;
    logic [SH_W-1:0]  sh_word;
    logic             ser_rise;
    dest_e            dest;
    logic             ref_load, div_load;
    logic [REF_W-1:0] ref_q;
    logic [DIV_W-1:0] div_q;

    ssl_shifter #(.SH_W(SH_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .ser_clk  (ser_clk),
        .ser_data (ser_data),
        .word     (sh_word),
        .rise     (ser_rise)
    );

    assign dest     = dest_e'(sh_word[0]);
    assign ref_load = load_en && (dest == DEST_REF);
    assign div_load = load_en && (dest == DEST_DIV);

    ssl_hold_reg #(.W(REF_W)) u_ref (
        .clk  (clk),
        .rst  (rst),
        .load (ref_load),
        .din  (sh_word[REF_W:1]),
        .q    (ref_q)
    );

    ssl_hold_reg #(.W(DIV_W)) u_div (
        .clk  (clk),
        .rst  (rst),
        .load (div_load),
        .din  (sh_word[DIV_W:1]),
        .q    (div_q)
    );

    always_comb begin
        ts_d    = ts_q;
        ts_d.sw = load_en;
        if (rst) begin
            ts_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        ts_q <= ts_d;
    end

    assign ref_count     = ref_q[REF_W-1:1];
    assign mod_sel       = ref_q[0];
    assign swallow_count = div_q[SWAL_W-1:0];
    assign main_count    = div_q[DIV_W-1:SWAL_W];
    assign sw_en         = ts_q.sw;
endmodule

// File: rtl/synth_serial_loader_chk.sv
module synth_serial_loader_chk #(
    parameter int REF_CNT_W = 14,
    parameter int SWAL_W    = 7,
    parameter int MAIN_W    = 11,
    parameter int SH_W      = 19
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 load_en,
    input logic                 ser_rise,
    input logic [SH_W-1:0]      sh_word,
    input logic [REF_CNT_W-1:0] ref_count,
    input logic                 mod_sel,
    input logic [SWAL_W-1:0]    swallow_count,
    input logic [MAIN_W-1:0]    main_count,
    input logic                 sw_en
);
    logic live_q = 1'b0;
    always_ff @(posedge clk) live_q <= !rst;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (ref_count == '0 && !mod_sel && swallow_count == '0 &&
                 main_count == '0 && !sw_en));

    assert_no_shift_without_edge_R2: assert property (@(posedge clk) disable iff (rst)
        (live_q && !$past(ser_rise)) |-> $stable(sh_word));

    assert_ref_keeps_div_R3: assert property (@(posedge clk) disable iff (rst)
        (live_q && $past(load_en) && $past(sh_word[0])) |->
        ($stable(swallow_count) && $stable(main_count) &&
         {ref_count, mod_sel} == $past(sh_word[REF_CNT_W+1:1])));

    assert_div_keeps_ref_R4: assert property (@(posedge clk) disable iff (rst)
        (live_q && $past(load_en) && !$past(sh_word[0])) |->
        ($stable(ref_count) && $stable(mod_sel) &&
         {main_count, swallow_count} == $past(sh_word[SWAL_W+MAIN_W:1])));

    assert_hold_when_idle_R5: assert property (@(posedge clk) disable iff (rst)
        (live_q && !$past(load_en)) |->
        ($stable(ref_count) && $stable(mod_sel) &&
         $stable(swallow_count) && $stable(main_count)));

    assert_switch_follows_R6: assert property (@(posedge clk) disable iff (rst)
        live_q |-> (sw_en == $past(load_en)));
endmodule

bind synth_serial_loader synth_serial_loader_chk #(
    .REF_CNT_W (REF_CNT_W),
    .SWAL_W    (SWAL_W),
    .MAIN_W    (MAIN_W),
    .SH_W      (SH_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .load_en       (load_en),
    .ser_rise      (ser_rise),
    .sh_word       (sh_word),
    .ref_count     (ref_count),
    .mod_sel       (mod_sel),
    .swallow_count (swallow_count),
    .main_count    (main_count),
    .sw_en         (sw_en)
);

// File: tb/synth_serial_loader_tb.sv
module synth_serial_loader_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_clk = 1'b0;
    logic        ser_data = 1'b0;
    logic        load_en = 1'b0;
    logic [13:0] ref_count;
    logic        mod_sel;
    logic [6:0]  swallow_count;
    logic [10:0] main_count;
    logic        sw_en;

    int checks = 0;
    int errors = 0;

    logic [13:0] exp_ref = '0;
    logic        exp_mod = 1'b0;
    logic [6:0]  exp_swl = '0;
    logic [10:0] exp_main = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    synth_serial_loader u_dut (
        .clk           (clk),
        .rst           (rst),
        .ser_clk       (ser_clk),
        .ser_data      (ser_data),
        .load_en       (load_en),
        .ref_count     (ref_count),
        .mod_sel       (mod_sel),
        .swallow_count (swallow_count),
        .main_count    (main_count),
        .sw_en         (sw_en)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic shift_bit(input logic b);
        @(negedge clk);
        ser_data = b;
        ser_clk  = 1'b1;
        @(negedge clk);
        ser_clk  = 1'b0;
    endtask

    task automatic shift_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) shift_bit(v[i]);
    endtask

    task automatic pulse_load();
        @(negedge clk);
        load_en = 1'b1;
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic check_all(input string req);
        check({req, " ref_count"}, 32'(ref_count), 32'(exp_ref));
        check({req, " mod_sel"}, 32'(mod_sel), 32'(exp_mod));
        check({req, " swallow"}, 32'(swallow_count), 32'(exp_swl));
        check({req, " main"}, 32'(main_count), 32'(exp_main));
    endtask

    task automatic load_ref(input logic [13:0] r, input logic m);
        shift_bits({17'd0, r, m, 1'b1}, 16);
        pulse_load();
        exp_ref = r;
        exp_mod = m;
    endtask

    task automatic load_div(input logic [10:0] mn, input logic [6:0] sw);
        shift_bits({13'd0, mn, sw, 1'b0}, 19);
        pulse_load();
        exp_main = mn;
        exp_swl  = sw;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        load_en = 1'b1;
        repeat (3) @(negedge clk);
        check_all("R1");
        check("R1 sw_en", 32'(sw_en), 32'd0);
        rst = 1'b0;
        load_en = 1'b0;
        @(negedge clk);

        // R3 R7 walking ones in reference count, modulus alternating
        for (int i = 0; i < 14; i++) begin
            load_ref(14'(1) << i, 1'(i % 2));
            check_all("R3 R7 walk");
        end
        load_ref(14'h3FFF, 1'b1);
        check_all("R3 R7 max");
        load_ref(14'h0000, 1'b0);
        check_all("R3 R7 zero");

        // R4 walking ones and arithmetic patterns in divider word
        for (int i = 0; i < 11; i++) begin
            load_div(11'(1) << i, 7'((i * 19 + 5) % 128));
            check_all("R4 walk");
        end
        load_div(11'h7FF, 7'h7F);
        check_all("R4 max");
        load_ref(14'h1A5C, 1'b1);
        check_all("R3 after div");

        // R5 frames shifted without load_en leave latches alone
        shift_bits({17'd0, 14'h0F0F, 1'b0, 1'b1}, 16);
        shift_bits({13'd0, 11'h123, 7'h45, 1'b0}, 19);
        repeat (2) @(negedge clk);
        check_all("R5 hold");

        // R6 switch enable tracks load_en one cycle later
        @(negedge clk);
        load_en = 1'b1;
        @(negedge clk);
        check("R6 high", 32'(sw_en), 32'd1);
        load_en = 1'b0;
        @(negedge clk);
        check("R6 low", 32'(sw_en), 32'd0);
        exp_main = 11'h123;
        exp_swl  = 7'h45;
        check_all("R4 pending frame");

        // R2 ser_clk held high shifts only once
        shift_bits({17'd0, 14'h2B3C, 1'b1}, 15);
        @(negedge clk);
        ser_data = 1'b1;
        ser_clk  = 1'b1;
        @(negedge clk);
        ser_data = 1'b0;
        repeat (4) @(negedge clk);
        ser_clk = 1'b0;
        pulse_load();
        exp_ref = 14'h2B3C;
        exp_mod = 1'b1;
        check_all("R2 single shift");

        // R8 shift and transfer at the same edge: pre-shift word is latched
        shift_bits({17'd0, 14'h1357, 1'b0, 1'b1}, 16);
        @(negedge clk);
        ser_data = 1'b0;
        ser_clk  = 1'b1;
        load_en  = 1'b1;
        @(negedge clk);
        ser_clk  = 1'b0;
        load_en  = 1'b0;
        exp_ref = 14'h1357;
        exp_mod = 1'b0;
        check_all("R8 same edge");

        // R9 load_en held high through a whole divider frame
        @(negedge clk);
        load_en = 1'b1;
        shift_bits({13'd0, 11'h5A6, 7'h19, 1'b0}, 19);
        @(negedge clk);
        check("R9 main", 32'(main_count), 32'h5A6);
        check("R9 swallow", 32'(swallow_count), 32'h19);
        load_en = 1'b0;

        @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule